// File: doc/BRIEF.md
# Zero-Stuff Interpolator with Digital Frequency Shifter

This block sits in a transmit datapath that runs at the output sample rate. It raises the rate of a complex (I/Q) sample stream by 1, 2, 4 or 8 by inserting zeros. It tells the upstream logic when it consumes an input pair by pulsing `take_o`. The pair is used only in that cycle, and every other slot of the output frame carries a zero. A half-band filter is expected outside the block. The block itself only provides the stuffed slots.

The stuffed stream can then be shifted in frequency by one half, one quarter or one eighth of the output rate. Each shift uses a fixed cosine/sine sequence indexed by a 3-bit phase counter. There are two output arrangements:

- In dual mode, each channel is multiplied by the cosine sequence on its own.
- In image-rejection (complex) mode, the two outputs are the real modulated signal and its quadrature partner.

All products are in Q15. Results that overrange clip to the 16-bit limits rather than wrap. Any change to the configuration restarts the slot and phase counters.

Top module: `zstuff_mixer`

## Requirements
- R1: `interp_sel` picks the rate factor N: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8. `take_o` is high in the first slot of each N-cycle frame and low in the other N-1 slots.
- R2: In the cycles where `take_o` is low, the stuffed sample on both channels is zero. With no frequency shift, both outputs are therefore 0 one cycle later.
- R3: The outputs register the result of cycle t at the following clock edge. With `interp_sel`=00 and `mod_sel`=00, `dout_a` equals the previous cycle's `din_i` and `dout_b` equals the previous cycle's `din_q`.
- R4: `mod_sel`=01 shifts by half the output rate. The cosine is +1 at even phase counts and -1 at odd ones, and the sine is 0.
- R5: `mod_sel`=10 shifts by a quarter of the output rate. For phase p mod 4, the cosine runs 1, 0, -1, 0 and the sine runs 0, 1, 0, -1.
- R6: `mod_sel`=11 shifts by an eighth of the output rate. For phase p mod 8:
  - the cosine runs 1, r, 0, -r, -1, -r, 0, r;
  - the sine runs 0, r, 1, r, 0, -r, -1, -r;
  - r is 23170/32768 and 1 is 32768/32768;
  - each output is (sum of products) arithmetically shifted right by 15 (floor).
- R7: With `cplx_en`=0, `dout_a` = I*cos and `dout_b` = Q*cos, where I and Q are the stuffed samples.
- R8: With `cplx_en`=1, `dout_a` = I*cos - Q*sin and `dout_b` = I*sin + Q*cos.
- R9: A result above 32767 is output as 32767, and a result below -32768 is output as -32768.
- R10: The phase counter advances by one every cycle. In a cycle where `{interp_sel, mod_sel, cplx_en}` differs from the previous cycle's value, the slot and phase are both taken as 0. In that cycle `take_o` is high, and counting resumes from there.
- R11: While `rst_n` is low, both outputs are 0. The first cycle after reset is slot 0 with phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| interp_sel | input | 2 | Rate factor code |
| mod_sel | input | 2 | Frequency shift code |
| cplx_en | input | 1 | 1 selects image-rejection output pair |
| din_i | input | 16 | In-phase input sample, two's complement |
| din_q | input | 16 | Quadrature input sample, two's complement |
| take_o | output | 1 | High in the cycle the input pair is consumed |
| dout_a | output | 16 | First output (real modulated / I channel) |
| dout_b | output | 16 | Second output (quadrature / Q channel) |

## Verification
The embedded properties check the following on every cycle:
- the spacing of `take_o` for each rate factor;
- the zero outputs in stuffed slots when no shift is applied;
- the one-stage pass-through when both fields are 00;
- that exactly one of cosine and sine is non-zero in the quarter-rate mode;
- the phase restart on a configuration change;
- the clipping at both limits.

The sweep over every combination of rate, shift and output mode shows the exact values of each sequence, including the rounded eighth-rate products and the complex sums. It also shows that counting resumes correctly after a change in the middle of a frame, which a single-cycle property cannot capture.

// File: rtl/zsm_pkg.sv
package zsm_pkg;

   localparam int COEF_W = 17;
   localparam int FRAC_W = 15;

   typedef enum logic [1:0] {
      MOD_NONE   = 2'b00,
      MOD_HALF   = 2'b01,
      MOD_QUART  = 2'b10,
      MOD_EIGHTH = 2'b11
   } mod_e;

   localparam logic signed [COEF_W-1:0] K_ONE = 17'sd32768;
   localparam logic signed [COEF_W-1:0] K_R2  = 17'sd23170;

   // Cosine of k*pi/4 in Q15, k taken modulo 8.
   function automatic logic signed [COEF_W-1:0] rot8(input logic [2:0] k);
      logic signed [COEF_W-1:0] v;
      case (k)
         3'd0:    v = K_ONE;
         3'd1:    v = K_R2;
         3'd2:    v = '0;
         3'd3:    v = -K_R2;
         3'd4:    v = -K_ONE;
         3'd5:    v = -K_R2;
         3'd6:    v = '0;
         default: v = K_R2;
      endcase
      return v;
   endfunction

   // Phase increment in eighths of a turn per output cycle.
   function automatic logic [2:0] step_of(input logic [1:0] m);
      logic [2:0] s;
      case (m)
         MOD_HALF:   s = 3'd4;
         MOD_QUART:  s = 3'd2;
         MOD_EIGHTH: s = 3'd1;
         default:    s = 3'd0;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/zsm_slot_ctr.sv
module zsm_slot_ctr #(
   parameter int SELW = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   input  logic [SELW-1:0] l2,
   output logic            take
);
   localparam int MAXL2 = (2 ** SELW) - 1;

   logic [MAXL2-1:0] slot, slot_use, slot_nxt, mask;

   always_comb begin
      mask     = MAXL2'((1 << l2) - 1);
      slot_use = restart ? '0 : slot;
      take     = (slot_use == '0);
      slot_nxt = (slot_use + MAXL2'(1)) & mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot <= '0;
      else        slot <= slot_nxt;
   end

   // R1: at factor 1 every cycle consumes a sample
   p_take_1x_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (l2 == '0) |-> take);

   // R1: after a consumed sample the next slot is a stuffed one unless restarted
   p_take_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (take && l2 != '0) |=> (!take || restart));

   // R1: at factor 2 a stuffed slot is followed by a consumed one
   p_take_2x_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (l2 == SELW'(1) && !take) |=> take);

endmodule

// File: rtl/zsm_phase_gen.sv
module zsm_phase_gen
   import zsm_pkg::*;
(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     restart,
   input  logic [1:0]               mode,
   output logic signed [COEF_W-1:0] cos_c,
   output logic signed [COEF_W-1:0] sin_c
);
   logic [2:0] ph, ph_use, ang;

   always_comb begin
      ph_use = restart ? 3'd0 : ph;
      ang    = ph_use * step_of(mode);
      cos_c  = rot8(ang);
      sin_c  = rot8(ang - 3'd2);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph <= 3'd0;
      else        ph <= ph_use + 3'd1;
   end

   // R10: a configuration change starts the sequence at angle zero
   p_phase_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> (cos_c == K_ONE && sin_c == '0));

   // R4: the half-rate shift has no sine term
   p_half_nosin_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MOD_HALF) |-> (sin_c == '0));

   // R5: at quarter rate exactly one of the two terms is non-zero
   p_quart_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MOD_QUART) |-> ((cos_c == '0) != (sin_c == '0)));

endmodule

// File: rtl/zsm_mix_lane.sv
module zsm_mix_lane
   import zsm_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [DW-1:0]     x,
   input  logic signed [COEF_W-1:0] cx,
   input  logic signed [DW-1:0]     y,
   input  logic signed [COEF_W-1:0] cy,
   output logic        [DW-1:0]     dout
);
   localparam int PW   = DW + COEF_W;
   localparam int ACCW = PW + 1;
   localparam longint MAXL = (longint'(1) << (DW - 1)) - 1;
   localparam logic signed [ACCW-1:0] SMAX = ACCW'(MAXL);
   localparam logic signed [ACCW-1:0] SMIN = ACCW'(-MAXL - 1);

   logic signed [PW-1:0]   px, py;
   logic signed [ACCW-1:0] acc, sh;
   logic        [DW-1:0]   nxt;

   always_comb begin
      px  = PW'(x) * PW'(cx);
      py  = PW'(y) * PW'(cy);
      acc = ACCW'(px) + ACCW'(py);
      sh  = acc >>> FRAC_W;
      if (sh > SMAX)      nxt = SMAX[DW-1:0];
      else if (sh < SMIN) nxt = SMIN[DW-1:0];
      else                nxt = sh[DW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout <= '0;
      else        dout <= nxt;
   end

   // R9: overrange clips to the positive limit
   p_sat_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sh > SMAX) |=> (dout == SMAX[DW-1:0]));

   // R9: underrange clips to the negative limit
   p_sat_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sh < SMIN) |=> (dout == SMIN[DW-1:0]));

endmodule

// File: rtl/zstuff_mixer.sv
module zstuff_mixer
   import zsm_pkg::*;
#(
   parameter int DW   = 16,
   parameter int SELW = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [SELW-1:0] interp_sel,
   input  logic [1:0]      mod_sel,
   input  logic            cplx_en,
   input  logic [DW-1:0]   din_i,
   input  logic [DW-1:0]   din_q,
   output logic            take_o,
   output logic [DW-1:0]   dout_a,
   output logic [DW-1:0]   dout_b
);
   localparam int CFGW  = SELW + 3;
   localparam int LANES = 2;

   if (DW < 4 || DW > 32) begin : g_bad_dw
      $error("zstuff_mixer: DW out of range");
   end
   if (SELW < 1 || SELW > 3) begin : g_bad_selw
      $error("zstuff_mixer: SELW out of range");
   end

   logic [CFGW-1:0] cfg_now, cfg_q;
   logic            restart;

   assign cfg_now = {interp_sel, mod_sel, cplx_en};
   assign restart = (cfg_now != cfg_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg_now;
   end

   zsm_slot_ctr #(.SELW(SELW)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .l2      (interp_sel),
      .take    (take_o)
   );

   logic signed [COEF_W-1:0] cos_c, sin_c;

   zsm_phase_gen u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .mode    (mod_sel),
      .cos_c   (cos_c),
      .sin_c   (sin_c)
   );

   logic signed [DW-1:0] zi, zq;
   assign zi = take_o ? din_i : '0;
   assign zq = take_o ? din_q : '0;

   logic signed [DW-1:0]     lx  [LANES];
   logic signed [DW-1:0]     ly  [LANES];
   logic signed [COEF_W-1:0] lcx [LANES];
   logic signed [COEF_W-1:0] lcy [LANES];
   logic        [DW-1:0]     lo  [LANES];

   always_comb begin
      // lane 0: I*cos, minus Q*sin in complex mode
      lx[0]  = zi;
      lcx[0] = cos_c;
      ly[0]  = zq;
      lcy[0] = cplx_en ? -sin_c : '0;
      // lane 1: Q*cos, plus I*sin in complex mode
      lx[1]  = zq;
      lcx[1] = cos_c;
      ly[1]  = zi;
      lcy[1] = cplx_en ? sin_c : '0;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      zsm_mix_lane #(.DW(DW)) u_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .x     (lx[g]),
         .cx    (lcx[g]),
         .y     (ly[g]),
         .cy    (lcy[g]),
         .dout  (lo[g])
      );
   end

   assign dout_a = lo[0];
   assign dout_b = lo[1];

   // R3: with no stuffing and no shift the block is a single register stage
   p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (interp_sel == '0 && mod_sel == MOD_NONE)
      |=> (dout_a == $past(din_i) && dout_b == $past(din_q)));

   // R2: a stuffed slot with no shift yields zero on both outputs
   p_zero_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!take_o && mod_sel == MOD_NONE) |=> (dout_a == '0 && dout_b == '0));

   // R10: any configuration change consumes a sample in that cycle
   p_restart_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> take_o);

endmodule

// File: tb/zstuff_mixer_tb_top.sv
module zstuff_mixer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  interp_sel = '0;
   logic [1:0]  mod_sel = '0;
   logic        cplx_en = 1'b0;
   logic [15:0] din_i = '0;
   logic [15:0] din_q = '0;
   logic        take_o;
   logic [15:0] dout_a, dout_b;

   always #5 clk = ~clk;

   zstuff_mixer dut_i (
      .clk(clk), .rst_n(rst_n), .interp_sel(interp_sel), .mod_sel(mod_sel),
      .cplx_en(cplx_en), .din_i(din_i), .din_q(din_q), .take_o(take_o),
      .dout_a(dout_a), .dout_b(dout_b)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;

   int     slot_m = 0;
   int     ph_m = 0;
   int     cfgq_m = 0;
   longint ea = 0, eb = 0;
   bit     ev = 0;
   string  etag = "";

   task automatic chk(input string req, input longint act, input longint exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic longint cos_m(input int m, input int p);
      case (m)
         1: return (p % 2) ? -32768 : 32768;
         2: case (p % 4) 0: return 32768; 2: return -32768; default: return 0; endcase
         3: case (p % 8)
               0: return 32768;  1: return 23170;  2: return 0;      3: return -23170;
               4: return -32768; 5: return -23170; 6: return 0;      default: return 23170;
            endcase
         default: return 32768;
      endcase
   endfunction

   function automatic longint sin_m(input int m, input int p);
      case (m)
         2: case (p % 4) 1: return 32768; 3: return -32768; default: return 0; endcase
         3: case (p % 8)
               0: return 0;      1: return 23170;  2: return 32768;  3: return 23170;
               4: return 0;      5: return -23170; 6: return -32768; default: return -23170;
            endcase
         default: return 0;
      endcase
   endfunction

   function automatic longint sat16(input longint v, inout bit hit);
      if (v > 32767) begin hit = 1; return 32767; end
      if (v < -32768) begin hit = 1; return -32768; end
      return v;
   endfunction

   task automatic step(input int il2, input int md, input int cx, input longint vi, input longint vq);
      int     cfg, s, p;
      bit     chg, tk, hit;
      longint zi, zq, c, sn;
      @(negedge clk);
      if (ev) begin
         chk({etag, " dout_a"}, longint'($signed(dout_a)), ea);
         chk({etag, " dout_b"}, longint'($signed(dout_b)), eb);
      end
      interp_sel = 2'(il2);
      mod_sel    = 2'(md);
      cplx_en    = cx[0];
      din_i      = 16'(vi);
      din_q      = 16'(vq);
      #1;
      cfg = (il2 << 3) | (md << 1) | cx;
      chg = (cfg != cfgq_m);
      s   = chg ? 0 : slot_m;
      p   = chg ? 0 : ph_m;
      tk  = (s == 0);
      // R1 take spacing; R10 restart on change
      chk(chg ? "R10 take_o" : "R1 take_o", longint'(take_o), longint'(tk));
      zi  = tk ? vi : 0;
      zq  = tk ? vq : 0;
      c   = cos_m(md, p);
      sn  = sin_m(md, p);
      hit = 0;
      if (cx != 0) begin
         ea = sat16((zi * c - zq * sn) >>> 15, hit);
         eb = sat16((zi * sn + zq * c) >>> 15, hit);
      end else begin
         ea = sat16((zi * c) >>> 15, hit);
         eb = sat16((zq * c) >>> 15, hit);
      end
      case (md)
         1: etag = "R4";
         2: etag = "R5";
         3: etag = "R6";
         default: etag = (il2 == 0) ? "R3" : "R2";
      endcase
      etag = {etag, (cx != 0) ? " R8" : " R7", hit ? " R9" : "", chg ? " R10" : ""};
      ev = 1;
      slot_m = (s + 1) % (1 << il2);
      ph_m   = (p + 1) % 8;
      cfgq_m = cfg;
   endtask

   function automatic longint pick(input int k, input bit second);
      case (k % 7)
         0: return -32768;
         3: return second ? -32768 : 32767;
         5: return second ? 32767 : 32767;
         default: return longint'($signed(16'($urandom)));
      endcase
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11 dout_a", longint'(dout_a), 0);
      chk("R11 dout_b", longint'(dout_b), 0);
      #1;
      chk("R11 take_o", longint'(take_o), 1);
      rst_n = 1'b1;
      for (int cx = 0; cx < 2; cx++)
         for (int md = 0; md < 4; md++)
            for (int il = 0; il < 4; il++)
               for (int k = 0; k < 43; k++)
                  step(il, md, cx, pick(k, 0), pick(k + 1, 1));
      // R10: toggle only the complex flag in mid-frame
      for (int k = 0; k < 13; k++) step(1, 3, 0, pick(k, 0), pick(k, 1));
      for (int k = 0; k < 13; k++) step(1, 3, 1, pick(k, 0), pick(k, 1));
      step(0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0);
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule